// File: doc/BRIEF.md
# Digitally Trimmed One-Second Prescaler

This block turns a clock-enable that pulses at the crystal rate (nominally 32,768 pulses per second) into a one-cycle tick each second. It corrects the crystal's rate error by digital means instead of analog trimming. The block keeps a 64-minute correction cycle. In the opening minutes of that cycle, the first second of each minute is made shorter or longer by a fixed number of oscillator pulses. With the default parameters that number is 128, which matches moving one step at the divide-by-256 stage.

A five-bit magnitude N and a direction bit control the correction. Minutes 0 through 2N-1 of the cycle are affected. Direction 1 shortens the affected second, so the clock gains. Direction 0 lengthens it, so the clock loses. Both values are captured only at a minute boundary. Minute boundaries come from an internal count of seconds, or from an external one-cycle minute pulse when the select pin is high. A stop pin freezes the divider and the minute sequencing. When stop is released, counting resumes from the point where it paused.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `sec_tick` and `min_strobe` are 0 and `min_index` is 63. The first second after reset lasts OSC_CYC enable pulses, whatever the calibration inputs are.
- R2: Each second lasts a whole number of `osc_en` pulses, nominally OSC_CYC. `sec_tick` is high for exactly the one clock cycle after the cycle that carries the final counted pulse. Cycles with `osc_en` low do not advance the divider.
- R3: In internal mode, `min_strobe` pulses together with the tick that ends every SEC_PER_MIN-th second. `min_index` then advances by one and wraps from 63 to 0. At all other times `min_index` holds its value.
- R4: With direction 1 and magnitude N > 0, the first second of a minute whose index is below 2N lasts OSC_CYC - ADJ_CYC pulses.
- R5: With direction 0 and magnitude N > 0, the first second of a minute whose index is below 2N lasts OSC_CYC + ADJ_CYC pulses.
- R6: Seconds other than the first second of a minute always last OSC_CYC pulses. So does the first second of a minute with index 2N or higher. With N = 31, minutes 62 and 63 are never adjusted.
- R7: A magnitude of 0 gives no adjustment, whatever the direction bit is.
- R8: The magnitude and direction are sampled only in the boundary cycle. A change made after a boundary has no effect until the next boundary. The second that is running when the change is made is never adjusted.
- R9: While `stop` is 1, the block produces no `sec_tick` and no `min_strobe`, and `min_index` holds. The divider count holds too, so after release the next tick comes after the pulses that were still remaining in that second.
- R10: With `ext_min_sel` high, an `ext_min` pulse (ignored while stopped) makes a boundary. `min_strobe` is high on the next cycle and `min_index` advances. The internal second count makes no boundary. The second that is running finishes at its own length, and the second that follows is treated as the first second of the new minute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| stop | input | 1 | 1 freezes the divider and minute sequencing |
| cal_mag | input | MAG_W (5) | Correction magnitude N; minutes 0..2N-1 affected |
| cal_fast | input | 1 | Direction: 1 shortens (gain), 0 lengthens (lose) |
| ext_min_sel | input | 1 | 1 takes minute boundaries from `ext_min` |
| ext_min | input | 1 | External minute pulse |
| sec_tick | output | 1 | One-cycle pulse per second |
| min_strobe | output | 1 | One-cycle pulse per minute boundary |
| min_index | output | MIN_W (6) | Position in the 64-minute correction cycle |

## Verification
The bench goes after the edges of the affected window. Minute 2N-1 must be adjusted and minute 2N must not be. With N = 31 that means minutes 61 and 62, and it includes the wrap from 63 to 0. A comparator that is off by one, or that compares against N instead of 2N, shows up there as one wrong second length. The bench changes the calibration just after a boundary and checks the running second. A design that applies new values at once would shorten or lengthen that second early. The stop test pauses in the middle of a second and measures the remainder after release. A design that clears the count when stopped, or lets an external minute pulse through, would give the wrong remainder or a stray strobe. External-minute mode checks that the second already running is left alone and only the following second is adjusted. Gating `osc_en` at half rate confirms that the divider counts enable pulses and not clock cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // Length class requested for the next second.
  typedef enum logic [1:0] {
    SEC_NOMINAL = 2'd0,
    SEC_SHORT   = 2'd1,
    SEC_LONG    = 2'd2
  } sec_len_e;
endpackage

// File: rtl/rtc_pulse_div.sv
module rtc_pulse_div
  import rtc_cal_pkg::*;
#(
  parameter int OSC_CYC = 32768,
  parameter int ADJ_CYC = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     osc_en,
  input  logic     hold,
  input  sec_len_e next_len,
  output logic     roll
);
  localparam int CNT_W = $clog2(OSC_CYC + ADJ_CYC);
  localparam logic [CNT_W-1:0] NOM_LAST   = CNT_W'(OSC_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(OSC_CYC - ADJ_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(OSC_CYC + ADJ_CYC - 1);

  logic [CNT_W-1:0] cnt_q, last_q, last_nxt;
  logic             step;

  assign step = osc_en & ~hold;
  assign roll = step & (cnt_q == last_q);

  always_comb begin
    unique case (next_len)
      SEC_SHORT: last_nxt = SHORT_LAST;
      SEC_LONG:  last_nxt = LONG_LAST;
      default:   last_nxt = NOM_LAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= NOM_LAST;
    end else if (step) begin
      if (roll) begin
        cnt_q  <= '0;
        last_q <= last_nxt;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_corr_seq.sv
module rtc_corr_seq
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_W       = 6,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             roll,
  input  logic             hold,
  input  logic             ext_sel,
  input  logic             ext_min,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_fast,
  output logic             bnd,
  output logic [MIN_W-1:0] min_idx,
  output sec_len_e         next_len
);
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam int CMP_W = (MIN_W > MAG_W + 1) ? MIN_W : MAG_W + 1;

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] idx_q, idx_n;
  logic [MAG_W-1:0] mag_q, mag_n;
  logic             fast_q, fast_n, first_q, first_n;
  logic             int_bnd, hit;

  assign int_bnd = roll & (sec_q == SEC_LAST);
  assign bnd     = ext_sel ? (ext_min & ~hold) : int_bnd;

  assign idx_n   = bnd ? idx_q + 1'b1 : idx_q;
  assign mag_n   = bnd ? cal_mag : mag_q;
  assign fast_n  = bnd ? cal_fast : fast_q;
  assign first_n = bnd | first_q;

  // Window test: index below twice the magnitude.
  assign hit = first_n & (CMP_W'(idx_n) < CMP_W'({mag_n, 1'b0}));

  always_comb begin
    if (!hit)        next_len = SEC_NOMINAL;
    else if (fast_n) next_len = SEC_SHORT;
    else             next_len = SEC_LONG;
  end

  assign min_idx = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= '0;
      idx_q   <= '1;
      mag_q   <= '0;
      fast_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (roll) sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
      if (bnd) begin
        idx_q  <= idx_n;
        mag_q  <= cal_mag;
        fast_q <= cal_fast;
      end
      first_q <= roll ? 1'b0 : first_n;
    end
  end
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int OSC_CYC     = 32768,
  parameter int ADJ_CYC     = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_W       = 6,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             stop,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_fast,
  input  logic             ext_min_sel,
  input  logic             ext_min,
  output logic             sec_tick,
  output logic             min_strobe,
  output logic [MIN_W-1:0] min_index
);
  logic     roll, bnd;
  sec_len_e next_len;

  rtc_pulse_div #(.OSC_CYC(OSC_CYC), .ADJ_CYC(ADJ_CYC)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .hold(stop),
    .next_len(next_len), .roll(roll)
  );

  rtc_corr_seq #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_W(MIN_W), .MAG_W(MAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .roll(roll), .hold(stop),
    .ext_sel(ext_min_sel), .ext_min(ext_min), .cal_mag(cal_mag),
    .cal_fast(cal_fast), .bnd(bnd), .min_idx(min_index), .next_len(next_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_tick   <= 1'b0;
      min_strobe <= 1'b0;
    end else begin
      sec_tick   <= roll;
      min_strobe <= bnd;
    end
  end
endmodule

// File: rtl/rtc_cal_prescaler_chk.sv
module rtc_cal_prescaler_chk #(
  parameter int OSC_CYC = 32768,
  parameter int ADJ_CYC = 128,
  parameter int MIN_W   = 6,
  parameter int MAG_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             stop,
  input logic             ext_min_sel,
  input logic             ext_min,
  input logic             sec_tick,
  input logic             min_strobe,
  input logic [MIN_W-1:0] min_index
);
  int per_cnt;
  logic step;
  assign step = osc_en & ~stop;

  // Counts enable pulses since the last tick, so second lengths are checked without a long $past.
  always_ff @(posedge clk) begin
    if (!rst_n)        per_cnt <= 0;
    else if (sec_tick) per_cnt <= step ? 1 : 0;
    else if (step)     per_cnt <= per_cnt + 1;
  end

  a_r9_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sec_tick);

  a_r9_minute_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ($stable(min_index) && !min_strobe));

  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    min_strobe |-> (min_index == MIN_W'($past(min_index) + 1'b1)));

  a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !min_strobe |-> $stable(min_index));

  a_r2_second_length: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (per_cnt == OSC_CYC || per_cnt == OSC_CYC - ADJ_CYC ||
                  per_cnt == OSC_CYC + ADJ_CYC));

  a_r10_ext_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_min_sel && ext_min && !stop) |=> min_strobe);
endmodule

bind rtc_cal_prescaler rtc_cal_prescaler_chk #(
  .OSC_CYC(OSC_CYC), .ADJ_CYC(ADJ_CYC), .MIN_W(MIN_W), .MAG_W(MAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
  .ext_min_sel(ext_min_sel), .ext_min(ext_min), .sec_tick(sec_tick),
  .min_strobe(min_strobe), .min_index(min_index)
);

// File: tb/rtc_cal_prescaler_test.sv
`timescale 1ns/1ps
module rtc_cal_prescaler_test;
  localparam int OSC = 32;
  localparam int ADJ = 8;
  localparam int SPM = 3;

  typedef struct packed {
    logic [4:0] mag;
    logic       fast;
    logic [7:0] nmin;
  } vec_t;

  localparam int VEC_N = 6;
  localparam vec_t VECS [VEC_N] = '{
    '{5'd0,  1'b1, 8'd2},   // R7: zero magnitude with gain direction
    '{5'd3,  1'b1, 8'd8},   // R4: minutes 0..5 shortened
    '{5'd3,  1'b0, 8'd8},   // R5: minutes 0..5 lengthened
    '{5'd0,  1'b0, 8'd2},   // R7
    '{5'd31, 1'b1, 8'd66},  // R6: full cycle, 61 vs 62 edge and wrap
    '{5'd1,  1'b0, 8'd3}    // R5 narrow window
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b1;
  logic stop = 1'b0;
  logic [4:0] cal_mag = '0;
  logic cal_fast = 1'b0;
  logic ext_min_sel = 1'b0;
  logic ext_min = 1'b0;
  logic sec_tick, min_strobe;
  logic [5:0] min_index;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_idx = 63;
  int lat_mag = 0, pend_mag = 0;
  bit lat_fast = 0, pend_fast = 0;

  always #5 clk = ~clk;

  rtc_cal_prescaler #(.OSC_CYC(OSC), .ADJ_CYC(ADJ), .SEC_PER_MIN(SPM)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
    .cal_mag(cal_mag), .cal_fast(cal_fast), .ext_min_sel(ext_min_sel),
    .ext_min(ext_min), .sec_tick(sec_tick), .min_strobe(min_strobe),
    .min_index(min_index)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_len(input int idx, input int mag, input bit fast);
    if (mag != 0 && idx < 2 * mag) return fast ? OSC - ADJ : OSC + ADJ;
    return OSC;
  endfunction

  function automatic string model_tag(input int idx, input int mag, input bit fast);
    if (mag == 0) return "R7";
    if (idx >= 2 * mag) return "R6";
    return fast ? "R4" : "R5";
  endfunction

  task automatic count_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sec_tick);
  endtask

  // Waits for a boundary, applies new calibration mid-minute, measures two seconds.
  task automatic run_minute(input int mag, input bit fast);
    int n;
    string tag;
    do @(negedge clk); while (!min_strobe);
    lat_mag = pend_mag;
    lat_fast = pend_fast;
    exp_idx = (exp_idx + 1) % 64;
    chk("R3 index advance", int'(min_index), exp_idx);
    cal_mag = 5'(mag);
    cal_fast = fast;
    pend_mag = mag;
    pend_fast = fast;
    tag = model_tag(exp_idx, lat_mag, lat_fast);
    if (mag != lat_mag || fast != lat_fast) tag = {tag, "/R8 late change"};
    count_to_tick(n);
    chk(tag, n, model_len(exp_idx, lat_mag, lat_fast));
    count_to_tick(n);
    chk("R6 second of minute", n, OSC);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (every requirement): got hang expected completion");
      finish_run();
    end
  end

  initial begin
    int n;
    int held;
    bit bad;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 tick in reset", int'(sec_tick), 0);
    chk("R1 strobe in reset", int'(min_strobe), 0);
    chk("R1 index in reset", int'(min_index), 63);
    rst_n = 1'b1;
    count_to_tick(n);
    chk("R1 first second", n, OSC);

    // Vector walk
    for (int v = 0; v < VEC_N; v++) begin
      for (int m = 0; m < int'(VECS[v].nmin); m++)
        run_minute(int'(VECS[v].mag), VECS[v].fast);
    end
    run_minute(0, 1'b0);
    run_minute(0, 1'b0);

    // R9: stop in the middle of a nominal third second
    repeat (5) @(negedge clk);
    stop = 1'b1;
    held = int'(min_index);
    bad = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sec_tick || min_strobe || int'(min_index) != held) bad = 1'b1;
    end
    chk("R9 frozen while stopped", int'(bad), 0);
    stop = 1'b0;
    count_to_tick(n);
    chk("R9 remainder after release", n, OSC - 5);
    chk("R3 boundary after stop", int'(min_strobe), 1);
    exp_idx = (exp_idx + 1) % 64;
    lat_mag = pend_mag;
    lat_fast = pend_fast;
    chk("R3 index after stop", int'(min_index), exp_idx);

    // R10: external minute pulse mid-second
    ext_min_sel = 1'b1;
    cal_mag = 5'd31;
    cal_fast = 1'b0;
    pend_mag = 31;
    pend_fast = 1'b0;
    n = 0;
    repeat (3) begin
      @(negedge clk);
      n++;
    end
    ext_min = 1'b1;
    @(negedge clk);
    n++;
    ext_min = 1'b0;
    exp_idx = (exp_idx + 1) % 64;
    lat_mag = 31;
    lat_fast = 1'b0;
    chk("R10 external strobe", int'(min_strobe), 1);
    chk("R10 external index", int'(min_index), exp_idx);
    while (!sec_tick) begin
      @(negedge clk);
      n++;
    end
    chk("R10 running second untouched", n, OSC);
    count_to_tick(n);
    chk("R10 following second adjusted", n, model_len(exp_idx, 31, 1'b0));
    count_to_tick(n);
    chk("R10 later second nominal", n, OSC);
    bad = 1'b0;
    for (int i = 0; i < 4 * SPM * (OSC + ADJ); i++) begin
      @(negedge clk);
      if (min_strobe) bad = 1'b1;
    end
    chk("R10 internal count ignored", int'(bad), 0);

    // Back to internal mode
    cal_mag = '0;
    cal_fast = 1'b0;
    pend_mag = 0;
    pend_fast = 1'b0;
    ext_min_sel = 1'b0;
    run_minute(0, 1'b0);

    // R2: half-rate enable doubles the period in clock cycles
    osc_en = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (sec_tick) break;
      osc_en = ~osc_en;
    end
    osc_en = 1'b1;
    chk("R2 enable-gated count", n, 2 * OSC);
    chk("R3 strobe with third tick", int'(min_strobe), 1);
    exp_idx = (exp_idx + 1) % 64;
    chk("R3 index after half rate", int'(min_index), exp_idx);

    // R1: reset mid-run with calibration inputs non-zero
    cal_mag = 5'd31;
    cal_fast = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 tick after reset", int'(sec_tick), 0);
    chk("R1 strobe after reset", int'(min_strobe), 0);
    chk("R1 index after reset", int'(min_index), 63);
    rst_n = 1'b1;
    count_to_tick(n);
    chk("R1 first second after reset", n, OSC);

    done = 1'b1;
    finish_run();
  end
endmodule